// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines onto sixteen level-sensitive inputs of a legacy interrupt controller. Every line owns a one-byte routing register. A routing value below sixteen names the controller input that the line drives. A value of sixteen or more leaves the line unconnected. Any number of lines may be steered to the same input, and that input is the wired-OR of their levels.

Software programs the routing bytes through a 32-bit register-write port with byte enables. The port carries a word address, so one write can change several routing bytes at once. On every write that touches a routing byte, the block throws away its level map and rebuilds it from the present line levels under the new routing. An input whose last source has been moved elsewhere therefore drops on the same clock edge.

Two small combinational helpers come with the block. The swizzle helper turns a device's slot number and its INTx pin into the shared line that the pin lands on. The route query reports, for a given line, whether the line is connected and to which input.

Top module: `pirq_router`

## Requirements
- R1: The routing byte of line l (l = 0..3) sits at byte offset 0x60+l, which is word 0x18 (wr_word = 6'h18) at byte lane l (wr_data[8l+7:8l]). The byte is written only when wr_en is high, wr_word is 6'h18 and wr_be[l] is set.
- R2: Under reset every routing byte becomes 0x80, so every line starts disconnected. The level map clears, all of irq_out is 0, and the query reports the line as disabled.
- R3: While a line's routing byte is 16 or greater, its level has no effect on any bit of irq_out, and the query reports qry_en = 0 for it.
- R4: While a line's routing byte is below 16, the query reports qry_en = 1 and qry_irq equal to the low four bits of that byte.
- R5: irq_out[k] is the OR of the levels of all connected lines routed to k, as sampled at the previous clock edge. A level that falls releases its output one cycle later, unless another line routed to the same output is still high.
- R6: A write that hits any routing byte rebuilds the whole map on that edge from the present levels and the new routing. From the next cycle the outputs follow the new routing, and an output whose sources have all moved away deasserts.
- R7: The swizzle output is swz_line = (swz_pin + swz_slot + 3) mod 4, that is (pin + slot - 1) mod 4, where slot is bits [7:3] of the device-function number.
- R8: A write whose word address differs from 6'h18, or whose byte enables are all zero, leaves every routing byte and every output unchanged.
- R9: One line drives at most one output, so the number of asserted outputs never exceeds the number of lines that were high at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 6 | Word address of the write (byte offset divided by 4) |
| wr_data | input | 32 | Write data, byte lane n in bits [8n+7:8n] |
| wr_be | input | 4 | Byte-lane enables |
| lvl_in | input | 4 | Present level of each shared interrupt line |
| irq_out | output | 16 | Levels driven onto the interrupt-controller inputs |
| qry_line | input | 2 | Line whose route is queried |
| qry_en | output | 1 | Queried line is connected |
| qry_irq | output | 4 | Output number of the queried line |
| swz_slot | input | 5 | Device slot number |
| swz_pin | input | 2 | Device INTx pin (0 = INTA) |
| swz_line | output | 2 | Shared line the pin is swizzled onto |

## Verification
The bench steers two lines onto one output and drops them one at a time. A design that kept only one source per output would release the output too early. It re-routes a line while the line is high and checks that the old output falls on the rebuild edge, so a stale map bit would show up as a stuck output. It also toggles disconnected lines, uses routing values right at 15 and 16, and makes writes with partial byte enables and with off-target word addresses. These catch an off-by-one in the disable threshold and a write that spills into the wrong lane.

// File: rtl/pirq_pkg.sv
// Shared constants and helpers for the PCI interrupt line router.
// Assumes a routing register is one byte wide and the write port is 32 bits.
package pirq_pkg;
    localparam int ROUTE_W    = 8;
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / ROUTE_W;
    localparam logic [ROUTE_W-1:0] ROUTE_RST = 8'h80;

    // True when a routing value names a real output (below n_outs).
    function automatic logic route_live(input logic [ROUTE_W-1:0] r, input int n_outs);
        return int'(r) < n_outs;
    endfunction
endpackage

// File: rtl/pirq_route_regs.sv
// Routing register bank: one byte per shared line, written through a
// 32-bit word port with byte enables. Assumes line l lives at byte
// offset BASE_OFF + l. Gives out the registered routing (route_q), the
// value it takes at the next edge (route_d) and a flag for any hit.
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter int N_LINES  = 4,
    parameter int AW       = 6,
    parameter int BASE_OFF = 'h60
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     wr_word,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [LANES-1:0]                  wr_be,
    output logic [N_LINES-1:0][ROUTE_W-1:0]   route_q,
    output logic [N_LINES-1:0][ROUTE_W-1:0]   route_d,
    output logic                              route_hit
);
    logic [N_LINES-1:0] sel;

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        localparam int OFF  = BASE_OFF + l;
        localparam int LANE = OFF % LANES;
        localparam logic [AW-1:0] WORD = AW'(OFF / LANES);

        // Decode a write to this line's byte and form its next value.
        always_comb begin
            sel[l]     = wr_en && (wr_word == WORD) && wr_be[LANE];
            route_d[l] = sel[l] ? wr_data[LANE*ROUTE_W +: ROUTE_W] : route_q[l];
        end

        // Hold the routing byte; reset leaves the line disconnected.
        always_ff @(posedge clk) begin
            if (!rst_n) route_q[l] <= ROUTE_RST;
            else        route_q[l] <= route_d[l];
        end
    end

    assign route_hit = |sel;
endmodule

// File: rtl/pirq_level_map.sv
// Level map: one bit per (output, line) pair at index out*N_LINES + line.
// On a routing write the map is cleared and rebuilt from the present
// levels under the new routing. Otherwise each connected line refreshes
// its own bit. Assumes route_d equals the registered routing when
// rebuild is low.
module pirq_level_map
    import pirq_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int N_OUTS  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rebuild,
    input  logic [N_LINES-1:0][ROUTE_W-1:0]   route_d,
    input  logic [N_LINES-1:0]                lvl,
    output logic [N_OUTS*N_LINES-1:0]         map_q
);
    localparam int MAP_N = N_OUTS * N_LINES;
    localparam int MW    = $clog2(MAP_N);
    localparam int OW    = $clog2(N_OUTS);

    logic [MAP_N-1:0] map_d;

    // Next map: start clean on a rebuild, then place each connected line.
    always_comb begin
        map_d = rebuild ? '0 : map_q;
        for (int l = 0; l < N_LINES; l++) begin
            if (route_live(route_d[l], N_OUTS)) begin
                map_d[MW'(route_d[l][OW-1:0]) * MW'(N_LINES) + MW'(l)] = lvl[l];
            end
        end
    end

    // Map register, all clear under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end
endmodule

// File: rtl/pirq_out_or.sv
// Output stage: each controller input is the OR of its N_LINES map bits.
// Purely combinational.
module pirq_out_or #(
    parameter int N_LINES = 4,
    parameter int N_OUTS  = 16
) (
    input  logic [N_OUTS*N_LINES-1:0] map_q,
    output logic [N_OUTS-1:0]         irq_out
);
    for (genvar k = 0; k < N_OUTS; k++) begin : g_out
        assign irq_out[k] = |map_q[k*N_LINES +: N_LINES];
    end
endmodule

// File: rtl/pirq_swizzle.sv
// Slot swizzle: a device's INTx pin lands on line (pin + slot - 1) mod
// N_LINES. Purely combinational.
module pirq_swizzle #(
    parameter int N_LINES = 4,
    parameter int SLOT_W  = 5
) (
    input  logic [SLOT_W-1:0]          slot,
    input  logic [$clog2(N_LINES)-1:0] pin,
    output logic [$clog2(N_LINES)-1:0] line
);
    localparam int LW = $clog2(N_LINES);

    // Add the pin to the slot with a minus-one bias, wrapped to the line count.
    always_comb begin
        line = LW'((int'(pin) + int'(slot) + N_LINES - 1) % N_LINES);
    end
endmodule

// File: rtl/pirq_router.sv
// PCI interrupt line router top. Ties the routing registers, the level
// map, the OR stage, the route query and the slot swizzle together.
// Assumes N_LINES and N_OUTS are powers of two and the routing bytes
// share one 32-bit word.
module pirq_router
    import pirq_pkg::*;
#(
    parameter int N_LINES  = 4,
    parameter int N_OUTS   = 16,
    parameter int AW       = 6,
    parameter int BASE_OFF = 'h60,
    parameter int SLOT_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_word,
    input  logic [31:0]                wr_data,
    input  logic [3:0]                 wr_be,
    input  logic [N_LINES-1:0]         lvl_in,
    output logic [N_OUTS-1:0]          irq_out,
    input  logic [$clog2(N_LINES)-1:0] qry_line,
    output logic                       qry_en,
    output logic [$clog2(N_OUTS)-1:0]  qry_irq,
    input  logic [SLOT_W-1:0]          swz_slot,
    input  logic [$clog2(N_LINES)-1:0] swz_pin,
    output logic [$clog2(N_LINES)-1:0] swz_line
);
    localparam int OW = $clog2(N_OUTS);

    logic [N_LINES-1:0][ROUTE_W-1:0] route_q;
    logic [N_LINES-1:0][ROUTE_W-1:0] route_d;
    logic                            route_hit;
    logic [N_OUTS*N_LINES-1:0]       map_q;
    logic [ROUTE_W-1:0]              qry_route;

    pirq_route_regs #(.N_LINES(N_LINES), .AW(AW), .BASE_OFF(BASE_OFF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_data(wr_data), .wr_be(wr_be), .route_q(route_q),
        .route_d(route_d), .route_hit(route_hit)
    );

    pirq_level_map #(.N_LINES(N_LINES), .N_OUTS(N_OUTS)) u_map (
        .clk(clk), .rst_n(rst_n), .rebuild(route_hit), .route_d(route_d),
        .lvl(lvl_in), .map_q(map_q)
    );

    pirq_out_or #(.N_LINES(N_LINES), .N_OUTS(N_OUTS)) u_or (
        .map_q(map_q), .irq_out(irq_out)
    );

    pirq_swizzle #(.N_LINES(N_LINES), .SLOT_W(SLOT_W)) u_swz (
        .slot(swz_slot), .pin(swz_pin), .line(swz_line)
    );

    // Route query: report the registered routing of the selected line.
    always_comb begin
        qry_route = route_q[qry_line];
        qry_en    = route_live(qry_route, N_OUTS);
        qry_irq   = qry_route[OW-1:0];
    end
endmodule

// File: rtl/pirq_router_chk.sv
// Assertion checker for pirq_router, attached by the bind below.
// Sees only the top-level ports.
module pirq_router_chk #(
    parameter int N_LINES = 4,
    parameter int N_OUTS  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [N_LINES-1:0] lvl_in,
    input logic [N_OUTS-1:0]  irq_out
);
    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_out == '0);

    // R5
    needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> ($past(lvl_in) != '0));

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= $countones($past(lvl_in)));

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wr_en && $stable(lvl_in)) |=> $stable(irq_out));
endmodule

bind pirq_router pirq_router_chk #(.N_LINES(N_LINES), .N_OUTS(N_OUTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lvl_in(lvl_in), .irq_out(irq_out)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_word = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [3:0]  lvl_in = '0;
    logic [15:0] irq_out;
    logic [1:0]  qry_line = '0;
    logic        qry_en;
    logic [3:0]  qry_irq;
    logic [4:0]  swz_slot = '0;
    logic [1:0]  swz_pin = '0;
    logic [1:0]  swz_line;

    int total = 0;
    int bad = 0;
    logic [7:0] mroute [4];

    pirq_router dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_data(wr_data), .wr_be(wr_be), .lvl_in(lvl_in), .irq_out(irq_out),
        .qry_line(qry_line), .qry_en(qry_en), .qry_irq(qry_irq),
        .swz_slot(swz_slot), .swz_pin(swz_pin), .swz_line(swz_line)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_out();
        logic [15:0] o = '0;
        for (int l = 0; l < 4; l++)
            if (mroute[l] < 8'd16 && lvl_in[l]) o[mroute[l][3:0]] = 1'b1;
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req);
        chk(req, {16'h0, irq_out}, {16'h0, exp_out()});
        for (int l = 0; l < 4; l++) begin
            qry_line = 2'(l);
            #1;
            chk({req, " R3/R4 query"}, {27'h0, qry_en, qry_irq},
                {27'h0, mroute[l] < 8'd16, mroute[l][3:0]});
        end
    endtask

    // Drive one write at a negedge; outputs are checked at the next negedge.
    task automatic do_write(input logic [5:0] w, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_word = w; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0;
        if (w == 6'h18)
            for (int b = 0; b < 4; b++) if (be[b]) mroute[b] = d[8*b +: 8];
    endtask

    task automatic set_lvl(input logic [3:0] v);
        lvl_in = v;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int l = 0; l < 4; l++) mroute[l] = 8'h80;
        lvl_in = 4'hF;
        repeat (3) @(negedge clk);
        chk_outs("R2 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R3 all disabled high levels");

        // R1/R4: route lines 0,1 to output 5, line 2 to 15, line 3 to 16 (off)
        set_lvl(4'h0);
        do_write(6'h18, 32'h10_0F_05_05, 4'hF);
        chk_outs("R1 full write");
        set_lvl(4'h3);
        chk_outs("R5 shared output");
        set_lvl(4'h2);
        chk_outs("R5 one source left");
        set_lvl(4'h0);
        chk_outs("R5 released");
        set_lvl(4'h8);
        chk_outs("R3 line at 16 ignored");
        set_lvl(4'h4);
        chk_outs("R4 route 15");

        // R6: move line 2 away while high
        do_write(6'h18, 32'h00_03_00_00, 4'h4);
        chk(" R6 old output dropped", {31'h0, irq_out[15]}, 32'h0);
        chk_outs("R6 rebuild");

        // R8: off-target word and empty enables
        do_write(6'h19, 32'h01_01_01_01, 4'hF);
        chk_outs("R8 other word");
        do_write(6'h18, 32'h01_01_01_01, 4'h0);
        chk_outs("R8 no enables");

        // R1 partial lane write
        do_write(6'h18, 32'hAA_BB_0C_DD, 4'h2);
        chk_outs("R1 lane 1 only");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 3));
            if (op == 0) begin
                logic [31:0] d;
                for (int b = 0; b < 4; b++)
                    d[8*b +: 8] = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(16, 255))
                                                              : 8'($urandom_range(0, 15));
                do_write(($urandom_range(0, 4) == 0) ? 6'($urandom) : 6'h18, d, 4'($urandom));
                chk_outs("R6 random write");
            end else begin
                set_lvl(4'($urandom));
                chk_outs("R5 random level");
            end
        end

        // R7 swizzle
        for (int i = 0; i < 40; i++) begin
            swz_slot = 5'($urandom);
            swz_pin  = 2'($urandom);
            #1;
            chk("R7 swizzle", {30'h0, swz_line},
                {30'h0, 2'((int'(swz_pin) + int'(swz_slot) + 3) % 4)});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule